// File: doc/BRIEF.md
# Interval Timer with Two Bidirectional Ports

This peripheral sits on a simple processor bus and offers two 8-bit general-purpose ports, a one-shot interval timer and an edge monitor on bit 7 of port A. Each port has a data register and a direction register. A direction bit of 1 makes that pin an output driven from the data register. A direction bit of 0 makes it an input, and reading the port returns the live pin level for that bit.

The timer is loaded with an 8-bit value. Four address bits on the load write take the place of a control register. Two of them choose the prescale (1, 8, 64 or 1024 clocks per count), one enables the timer interrupt, and one marks the access as a load. While the timer runs, reading it returns the remaining count in prescaled units. When the count passes zero, the timer raises a sticky flag. From then on it keeps stepping down once per clock with no prescale, so software can read how long ago the timer lapsed. The timer is a three-state machine: `TMR_IDLE` (never loaded), `TMR_RUN` (counting down) and `TMR_LAPSED` (flag set). Its transitions are IDLE→RUN on a load, RUN→RUN on a load or while the count is not zero, RUN→LAPSED when the count is zero, LAPSED→LAPSED while no load arrives, and LAPSED→RUN on a load.

The edge monitor watches `pa_in[7]` for a rising or a falling transition, whichever is selected. It records a hit in its own flag. An active-low interrupt combines both flags, each gated by its own enable.

Top module: `pit_io_timer`

## Requirements
- R1: After reset, the port data and direction registers are 0, `pa_oe`/`pb_oe`/`pa_out`/`pb_out` are 0, `irq_n` is 1, a timer read returns 0 and a flag read returns 0.
- R2: A write with addr[2]=0 stores `wdata` into port A data (addr[1:0]=0), port A direction (1), port B data (2) or port B direction (3). `px_out` shows the data register, `px_oe` shows the direction register, and a read of a direction address returns that register.
- R3: A read of a port data address (0 or 2) returns the data register bit where the direction bit is 1 and the input pin bit where it is 0.
- R4: A write with addr[2]=1 and addr[4]=1 loads the timer with `wdata`=D. addr[1:0]=0,1,2,3 selects a shift s of 0, 3, 6 or 10. A timer read (read with addr[2]=1, addr[0]=0) returns the remaining clock count shifted right by s, which is D in the cycle after the load.
- R5: After a load at clock edge L, the remaining count is D·2^s minus the edges since L. The timer flag is set after edge L+D·2^s+1, and the timer read then returns 0xFF.
- R6: Once lapsed, the timer read decrements by one every clock and wraps from 0x00 to 0xFF.
- R7: A load clears the timer flag and restarts counting, also when the timer has already lapsed. Address bit 3 of the load is the timer interrupt enable.
- R8: A write with addr[2]=1 and addr[4]=0 configures the edge monitor: addr[1]=1 enables its interrupt, addr[0]=1 selects rising and 0 selects falling. The edge flag is set on the selected transition of `pa_in[7]` whatever the enable is, and the other transition has no effect.
- R9: A flag read (read with addr[2]=1, addr[0]=1) returns the timer flag in bit 7 and the edge flag in bit 6, with the other bits 0. It clears the edge flag at the clock edge that ends the read. An edge that hits in that same cycle wins, and the flag stays set.
- R10: `irq_n` is 0 exactly when (timer flag and timer enable) or (edge flag and edge enable).
- R11: The timer flag stays set until the next load. Timer and flag reads do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Register and mode select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 when not reading) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B drive enables |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two functions can land in the same cycle: a flag read that clears the edge flag, and a selected transition on `pa_in[7]` that sets it. The bench drives the clearing read and the pin change on the same falling clock edge, so both reach the register at one rising edge. It expects the read to return bit 6 as 0 and a second flag read to return bit 6 as 1, showing that the hit was kept and not swallowed by the clear.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int DATA_W_DEF    = 8;
    localparam int MAX_SHIFT_DEF = 10;

    typedef enum logic [1:0] {
        TMR_IDLE   = 2'd0,
        TMR_RUN    = 2'd1,
        TMR_LAPSED = 2'd2
    } tmr_state_e;

    // prescale code -> shift amount; the slowest code uses max_sh
    function automatic int unsigned shift_of(input logic [1:0] sel, input int unsigned max_sh);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 3;
            2'd2:    return 6;
            default: return max_sh;
        endcase
    endfunction

endpackage

// File: rtl/pit_port.sv
module pit_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          dir_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] rd_val
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (data_wr) data_q <= wdata;
            if (dir_wr)  dir_q  <= wdata;
        end
    end

    always_comb rd_val = (data_q & dir_q) | (pin_in & ~dir_q);

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DW        = 8,
    parameter int MAX_SHIFT = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic [1:0]    load_sel,
    input  logic          load_ien,
    output logic [DW-1:0] rd_val,
    output logic          flag,
    output logic          ien
);

    localparam int CW = DW + MAX_SHIFT;

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] remain_q, remain_d;
    logic [1:0]    sel_q, sel_d;
    logic          ien_q, ien_d;
    logic [CW-1:0] scaled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= TMR_IDLE;
            remain_q <= '0;
            sel_q    <= '0;
            ien_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            sel_q    <= sel_d;
            ien_q    <= ien_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        sel_d    = sel_q;
        ien_d    = ien_q;
        if (load) begin
            state_d  = TMR_RUN;
            remain_d = CW'(load_val) << shift_of(load_sel, MAX_SHIFT);
            sel_d    = load_sel;
            ien_d    = load_ien;
        end else begin
            unique case (state_q)
                TMR_IDLE: ;
                TMR_RUN: begin
                    if (remain_q == '0) begin
                        state_d  = TMR_LAPSED;
                        remain_d = '1;
                    end else begin
                        remain_d = remain_q - 1'b1;
                    end
                end
                TMR_LAPSED: remain_d = remain_q - 1'b1;
                default:    state_d  = TMR_IDLE;
            endcase
        end
    end

    always_comb begin
        scaled = remain_q >> shift_of(sel_q, MAX_SHIFT);
        flag   = (state_q == TMR_LAPSED);
        ien    = ien_q;
        unique case (state_q)
            TMR_RUN:    rd_val = scaled[DW-1:0];
            TMR_LAPSED: rd_val = remain_q[DW-1:0];
            default:    rd_val = '0;
        endcase
    end

endmodule

// File: rtl/pit_edge.sv
module pit_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic cfg_wr,
    input  logic cfg_en,
    input  logic cfg_rise,
    input  logic clr,
    output logic flag,
    output logic en
);

    logic prev_q, armed_q, rise_q, hit;

    always_comb hit = armed_q && (rise_q ? (pin && !prev_q) : (!pin && prev_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            rise_q  <= 1'b0;
            en      <= 1'b0;
            flag    <= 1'b0;
        end else begin
            prev_q  <= pin;
            armed_q <= 1'b1;
            if (cfg_wr) begin
                en     <= cfg_en;
                rise_q <= cfg_rise;
            end
            if (hit)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/pit_io_timer.sv
module pit_io_timer
    import pit_pkg::*;
#(
    parameter int DATA_W    = DATA_W_DEF,
    parameter int MAX_SHIFT = MAX_SHIFT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [4:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    output logic              irq_n
);

    localparam int NPORT = 2;

    logic wr, rd, tmr_load, edge_cfg, flag_rd;
    logic t_flag, t_ien, e_flag, e_en;
    logic [DATA_W-1:0] t_val;
    logic [DATA_W-1:0] p_in   [NPORT];
    logic [DATA_W-1:0] p_data [NPORT];
    logic [DATA_W-1:0] p_dir  [NPORT];
    logic [DATA_W-1:0] p_rd   [NPORT];

    always_comb begin
        wr       = cs && we;
        rd       = cs && !we;
        tmr_load = wr && addr[2] && addr[4];
        edge_cfg = wr && addr[2] && !addr[4];
        flag_rd  = rd && addr[2] && addr[0];
    end

    assign p_in[0] = pa_in;
    assign p_in[1] = pb_in;

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        pit_port #(.DW(DATA_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .data_wr(wr && !addr[2] && (addr[1] == gi[0]) && !addr[0]),
            .dir_wr (wr && !addr[2] && (addr[1] == gi[0]) &&  addr[0]),
            .wdata  (wdata),
            .pin_in (p_in[gi]),
            .data_q (p_data[gi]),
            .dir_q  (p_dir[gi]),
            .rd_val (p_rd[gi])
        );
    end

    assign pa_out = p_data[0];
    assign pa_oe  = p_dir[0];
    assign pb_out = p_data[1];
    assign pb_oe  = p_dir[1];

    pit_timer #(.DW(DATA_W), .MAX_SHIFT(MAX_SHIFT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(wdata),
        .load_sel(addr[1:0]),
        .load_ien(addr[3]),
        .rd_val  (t_val),
        .flag    (t_flag),
        .ien     (t_ien)
    );

    pit_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (pa_in[DATA_W-1]),
        .cfg_wr  (edge_cfg),
        .cfg_en  (addr[1]),
        .cfg_rise(addr[0]),
        .clr     (flag_rd),
        .flag    (e_flag),
        .en      (e_en)
    );

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (!addr[2]) begin
                if (addr[0]) rdata = p_dir[addr[1]];
                else         rdata = p_rd[addr[1]];
            end else if (addr[0]) begin
                rdata = {t_flag, e_flag, {(DATA_W-2){1'b0}}};
            end else begin
                rdata = t_val;
            end
        end
    end

    assign irq_n = !((t_flag && t_ien) || (e_flag && e_en));

endmodule

// File: rtl/pit_io_timer_chk.sv
module pit_io_timer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              we,
    input logic              a4,
    input logic              a2,
    input logic [1:0]        a10,
    input logic              pa7,
    input logic [DATA_W-1:0] pa_oe,
    input logic              irq_n,
    input logic              t_flag,
    input logic              e_flag
);

    logic load_w, dira_w, flag_r;
    always_comb begin
        load_w = cs && we && a2 && a4;
        dira_w = cs && we && !a2 && (a10 == 2'd1);
        flag_r = cs && !we && a2 && a10[0];
    end

    assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> !t_flag);

    assert_flag_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (t_flag && !load_w) |=> t_flag);

    assert_edge_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (e_flag && !flag_r) |=> e_flag);

    assert_edge_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_flag) |-> ($past(pa7) != $past(pa7, 2)));

    assert_dir_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dira_w |=> $stable(pa_oe));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_flag && !e_flag) |-> irq_n);

endmodule

bind pit_io_timer pit_io_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .we    (we),
    .a4    (addr[4]),
    .a2    (addr[2]),
    .a10   (addr[1:0]),
    .pa7   (pa_in[DATA_W-1]),
    .pa_oe (pa_oe),
    .irq_n (irq_n),
    .t_flag(t_flag),
    .e_flag(e_flag)
);

// File: tb/pit_io_timer_test.sv
module pit_io_timer_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, we = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pa_in = '0, pa_out, pa_oe;
    logic [7:0] pb_in = '0, pb_out, pb_oe;
    logic       irq_n;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    localparam logic [4:0] A_TRD = 5'b00100;
    localparam logic [4:0] A_FRD = 5'b00101;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_io_timer uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks enter and leave at a falling edge
    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input string req, input logic [4:0] a, input logic [7:0] mask,
                          input logic [7:0] exp);
        cs = 1'b1; we = 1'b0; addr = a;
        #1 check(req, rdata & mask, exp);
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pin(input logic v);
        pa_in[7] = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pa_out", pa_out, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        bus_rd("R1 timer", A_TRD, 8'hFF, 8'h00);
        bus_rd("R1 flags", A_FRD, 8'hFF, 8'h00);
    endtask

    task automatic t_ports;
        bus_wr(5'd0, 8'hA5);
        bus_wr(5'd1, 8'h0F);
        bus_wr(5'd2, 8'h5A);
        bus_wr(5'd3, 8'hF0);
        pa_in = 8'h3C; pb_in = 8'h81;
        check("R2 pa_out", pa_out, 8'hA5);
        check("R2 pa_oe", pa_oe, 8'h0F);
        check("R2 pb_out", pb_out, 8'h5A);
        check("R2 pb_oe", pb_oe, 8'hF0);
        bus_rd("R2 dirB read", 5'd3, 8'hFF, 8'hF0);
        bus_rd("R3 portA mix", 5'd0, 8'hFF, 8'h35);
        bus_rd("R3 portB mix", 5'd2, 8'hFF, 8'h51);
        pa_in = 8'h00;
        @(negedge clk);
    endtask

    task automatic t_timer_div1;
        bus_wr(5'b11100, 8'd3);
        bus_rd("R4 after load", A_TRD, 8'hFF, 8'd3);
        bus_rd("R5 j1", A_TRD, 8'hFF, 8'd2);
        bus_rd("R5 j2", A_TRD, 8'hFF, 8'd1);
        check("R5 irq before lapse", {7'd0, irq_n}, 8'h01);
        bus_rd("R5 j3", A_TRD, 8'hFF, 8'd0);
        check("R10 irq on lapse", {7'd0, irq_n}, 8'h00);
        bus_rd("R5 lapsed FF", A_TRD, 8'hFF, 8'hFF);
        bus_rd("R6 next FE", A_TRD, 8'hFF, 8'hFE);
        bus_rd("R11 flag bit7", A_FRD, 8'h80, 8'h80);
        bus_rd("R11 flag again", A_FRD, 8'h80, 8'h80);
        check("R11 irq held", {7'd0, irq_n}, 8'h00);
    endtask

    task automatic t_timer_wrap;
        bus_wr(5'b10100, 8'd0);
        bus_rd("R5 zero load", A_TRD, 8'hFF, 8'd0);
        bus_rd("R5 zero lapse", A_TRD, 8'hFF, 8'hFF);
        idle(254);
        bus_rd("R6 reach 00", A_TRD, 8'hFF, 8'h00);
        bus_rd("R6 wrap FF", A_TRD, 8'hFF, 8'hFF);
    endtask

    task automatic t_timer_div8;
        bus_wr(5'b10101, 8'd2);
        bus_rd("R4 div8 j0", A_TRD, 8'hFF, 8'd2);
        bus_rd("R4 div8 j1", A_TRD, 8'hFF, 8'd1);
        idle(7);
        bus_rd("R4 div8 j9", A_TRD, 8'hFF, 8'd0);
        idle(6);
        bus_rd("R5 div8 j16 not lapsed", A_FRD, 8'h80, 8'h00);
        bus_rd("R5 div8 j17 lapsed", A_FRD, 8'h80, 8'h80);
        check("R7 no enable irq", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_timer_div1024;
        bus_wr(5'b11111, 8'd1);
        idle(1024);
        check("R5 div1024 edge 1024", {7'd0, irq_n}, 8'h01);
        idle(1);
        check("R5 div1024 edge 1025", {7'd0, irq_n}, 8'h00);
        bus_wr(5'b11100, 8'd5);
        check("R7 reload irq", {7'd0, irq_n}, 8'h01);
        bus_rd("R7 reload flag", A_FRD, 8'h80, 8'h00);
        bus_wr(5'b10110, 8'd1);
        bus_rd("R4 div64 j0", A_TRD, 8'hFF, 8'd1);
        bus_rd("R4 div64 j1", A_TRD, 8'hFF, 8'd0);
    endtask

    task automatic t_edges;
        bus_wr(5'b10111, 8'hFF);
        bus_rd("R9 clear", A_FRD, 8'h00, 8'h00);
        bus_wr(5'b00111, 8'h00);
        set_pin(1'b1);
        check("R8 rising irq", {7'd0, irq_n}, 8'h00);
        bus_rd("R9 edge bit6", A_FRD, 8'h40, 8'h40);
        check("R9 cleared irq", {7'd0, irq_n}, 8'h01);
        set_pin(1'b0);
        check("R8 falling ignored irq", {7'd0, irq_n}, 8'h01);
        bus_rd("R8 falling ignored flag", A_FRD, 8'hFF, 8'h00);
        bus_wr(5'b00110, 8'h00);
        set_pin(1'b1);
        check("R8 rise ignored in fall mode", {7'd0, irq_n}, 8'h01);
        set_pin(1'b0);
        check("R8 falling hit", {7'd0, irq_n}, 8'h00);
        bus_rd("R9 falling flag", A_FRD, 8'hFF, 8'h40);
        bus_wr(5'b00101, 8'h00);
        set_pin(1'b1);
        check("R10 disabled edge irq", {7'd0, irq_n}, 8'h01);
        bus_rd("R8 disabled still flags", A_FRD, 8'hFF, 8'h40);
    endtask

    task automatic t_same_cycle;
        set_pin(1'b0);
        cs = 1'b1; we = 1'b0; addr = A_FRD; pa_in[7] = 1'b1;
        #1 check("R9 read before hit", rdata, 8'h00);
        @(negedge clk);
        cs = 1'b0;
        bus_rd("R9 hit beats clear", A_FRD, 8'hFF, 8'h40);
        bus_rd("R9 then cleared", A_FRD, 8'hFF, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_ports();
        t_timer_div1();
        t_timer_wrap();
        t_timer_div8();
        t_timer_div1024();
        t_edges();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule